// File: doc/BRIEF.md
# Phase-0 SPI Slave with Edge-Counted Frame Completion

This block is the receiving end of a serial peripheral link, working in the mode where the first data bit must already be on the line before the clock starts. The serial clock, the data input and the active-low select are brought into the system clock domain through synchronisers. Clock transitions are then detected there and counted. One frame is fixed at eight bits, which is sixteen clock edges.

While the block is deselected it keeps copying the parallel transmit word. As soon as select is seen asserted, it enables its serial output and drives the first bit of that word, without waiting for a clock edge. Input bits are captured on the odd-numbered edges and the output moves to the next bit on the even-numbered edges. On the sixteenth edge the block publishes the received word, pulses a completion flag and advances a receive counter. The same edge reloads the transmit word, so frames can follow each other under one select.

A polarity input sets the idle level of the clock. A bit-order input chooses most- or least-significant bit first for both directions. Releasing select part-way through a frame throws away the partial frame.

Top module: `spis_cpha0_slave`

## Requirements
- R1: `miso_oe` is 0 while select is deasserted and becomes 1 within a few system cycles after `cs_n` goes low.
- R2: After select assertion and before any clock edge, `miso` carries `tx_data[7]` when `lsb_first`=0, or `tx_data[0]` when `lsb_first`=1.
- R3: With `lsb_first`=0 and `cpol`=0, one complete frame delivers the serial input bits into `rx_data` with the first received bit at bit 7. It also shifts out `tx_data` from bit 7 down to bit 0, advancing only on even edges.
- R4: With `lsb_first`=1, the first bit sent and the first bit received both map to bit 0, and later bits go in ascending order.
- R5: `rx_done` pulses for exactly one cycle and `rx_count` increments by one only on the 16th edge. After 15 edges, neither has changed.
- R6: With `cpol`=1 the clock idles high, and odd edges are high-to-low transitions. Frames then exchange data exactly as with `cpol`=0.
- R7: Deasserting select mid-frame raises no `rx_done`, leaves `rx_count` and `rx_data` unchanged, and the next frame starts from edge 1.
- R8: When select stays asserted across frames, the word on `tx_data` at the 16th edge becomes the next frame's transmit word.
- R9: After reset, `rx_count`=0, `rx_done`=0, `rx_data`=0 and `miso_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cpol | input | 1 | Clock idle level (0 low, 1 high) |
| lsb_first | input | 1 | 1: least significant bit first |
| sclk | input | 1 | External serial clock |
| cs_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| tx_data | input | 8 | Parallel word to transmit |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` |
| rx_data | output | 8 | Last completed received word |
| rx_done | output | 1 | One-cycle completion pulse |
| rx_count | output | 8 | Completed-frame counter, wraps |

## Verification
The checks assume that `cpol` and `lsb_first` stay constant while select is asserted. They also assume that each serial clock level lasts several system cycles, so that every level survives the synchronisers and no two edges merge. The bench holds each clock half-period for eight system cycles and keeps the configuration inputs fixed during every selected interval. It also places each data change together with an even edge, which is the point where the master is allowed to change its output.

// File: rtl/spis_pkg.sv
package spis_pkg;
    localparam int FRAME_BITS_DEF = 8;
    localparam int COUNT_W_DEF    = 8;
    localparam int SYNC_DEPTH_DEF = 2;

    typedef struct packed {
        logic lead;   // transition away from idle level (odd edge)
        logic trail;  // transition back to idle level (even edge)
    } sclk_edge_t;

    // Map a serial bit index to a word position for the chosen order.
    function automatic int bit_pos(input int idx, input int nbits, input logic lsb);
        return lsb ? idx : (nbits - 1 - idx);
    endfunction
endpackage

// File: rtl/spis_sync.sv
module spis_sync #(
    parameter int          WIDTH  = 3,
    parameter int          STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage[s] <= RST_VAL;
            else if (s == 0)
                stage[s] <= d;
            else
                stage[s] <= stage[(s == 0) ? 0 : s - 1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/spis_edge.sv
module spis_edge
    import spis_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cpol,
    input  logic       sclk_s,
    output sclk_edge_t edges
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= sclk_s;
    end

    always_comb begin
        edges.lead  = (prev == cpol) && (sclk_s != cpol);
        edges.trail = (prev != cpol) && (sclk_s == cpol);
    end
endmodule

// File: rtl/spis_core.sv
module spis_core
    import spis_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_BITS_DEF,
    parameter int COUNT_W    = COUNT_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lsb_first,
    input  logic                  sel,
    input  logic                  mosi_s,
    input  sclk_edge_t            edges,
    input  logic [FRAME_BITS-1:0] tx_data,
    output logic                  miso,
    output logic                  miso_oe,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  rx_done,
    output logic [COUNT_W-1:0]    rx_count
);
    localparam int IDX_W  = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam int EDGE_W = $clog2(2 * FRAME_BITS);
    localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * FRAME_BITS - 1);

    logic [EDGE_W-1:0]     ecnt;
    logic [IDX_W-1:0]      txi, rxi, tx_pos, rx_pos;
    logic [FRAME_BITS-1:0] tx_word, rx_shift;

    always_comb begin
        tx_pos = IDX_W'(bit_pos(int'(txi), FRAME_BITS, lsb_first));
        rx_pos = IDX_W'(bit_pos(int'(rxi), FRAME_BITS, lsb_first));
        miso   = tx_word[tx_pos];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ecnt     <= '0;
            txi      <= '0;
            rxi      <= '0;
            tx_word  <= '0;
            rx_shift <= '0;
            rx_data  <= '0;
            rx_done  <= 1'b0;
            rx_count <= '0;
            miso_oe  <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            miso_oe <= sel;
            if (!sel) begin
                ecnt    <= '0;
                txi     <= '0;
                rxi     <= '0;
                tx_word <= tx_data;
            end else if (edges.lead && !ecnt[0]) begin
                rx_shift[rx_pos] <= mosi_s;
                rxi  <= IDX_W'(rxi + 1'b1);
                ecnt <= ecnt + 1'b1;
            end else if (edges.trail && ecnt[0]) begin
                if (ecnt == LAST_EDGE) begin
                    ecnt     <= '0;
                    txi      <= '0;
                    rxi      <= '0;
                    tx_word  <= tx_data;
                    rx_data  <= rx_shift;
                    rx_done  <= 1'b1;
                    rx_count <= rx_count + 1'b1;
                end else begin
                    ecnt <= ecnt + 1'b1;
                    txi  <= IDX_W'(txi + 1'b1);
                end
            end
        end
    end
endmodule

// File: rtl/spis_cpha0_slave.sv
module spis_cpha0_slave
    import spis_pkg::*;
#(
    parameter int FRAME_BITS = FRAME_BITS_DEF,
    parameter int COUNT_W    = COUNT_W_DEF,
    parameter int SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpol,
    input  logic                  lsb_first,
    input  logic                  sclk,
    input  logic                  cs_n,
    input  logic                  mosi,
    input  logic [FRAME_BITS-1:0] tx_data,
    output logic                  miso,
    output logic                  miso_oe,
    output logic [FRAME_BITS-1:0] rx_data,
    output logic                  rx_done,
    output logic [COUNT_W-1:0]    rx_count
);
    logic [2:0] pins_s;
    logic       sel_s;
    sclk_edge_t edges;

    // bit 2: cs_n (idles high), bit 1: sclk, bit 0: mosi
    spis_sync #(.WIDTH(3), .STAGES(SYNC_DEPTH), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, mosi}),
        .q   (pins_s)
    );

    assign sel_s = ~pins_s[2];

    spis_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .cpol   (cpol),
        .sclk_s (pins_s[1]),
        .edges  (edges)
    );

    spis_core #(.FRAME_BITS(FRAME_BITS), .COUNT_W(COUNT_W)) u_core (
        .clk       (clk),
        .rst       (rst),
        .lsb_first (lsb_first),
        .sel       (sel_s),
        .mosi_s    (pins_s[0]),
        .edges     (edges),
        .tx_data   (tx_data),
        .miso      (miso),
        .miso_oe   (miso_oe),
        .rx_data   (rx_data),
        .rx_done   (rx_done),
        .rx_count  (rx_count)
    );
endmodule

// File: rtl/spis_chk.sv
module spis_chk #(
    parameter int FRAME_BITS = 8,
    parameter int COUNT_W    = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  sel,
    input logic                  miso_oe,
    input logic [FRAME_BITS-1:0] rx_data,
    input logic                  rx_done,
    input logic [COUNT_W-1:0]    rx_count
);
    // R1: output enable follows a deasserted select
    assert_oe_off_R1: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !miso_oe);

    // R5: completion flag is a single-cycle pulse
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    // R5: counter advances by one with each completion
    assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> rx_count == COUNT_W'($past(rx_count) + 1'b1));

    // R5: counter holds when no completion
    assert_count_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> $stable(rx_count));

    // R7: no completion while deselected
    assert_no_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !sel |=> !rx_done);

    // R7: received word changes only with a completion
    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rx_done |-> $stable(rx_data));
endmodule

bind spis_cpha0_slave spis_chk #(.FRAME_BITS(FRAME_BITS), .COUNT_W(COUNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel_s),
    .miso_oe  (miso_oe),
    .rx_data  (rx_data),
    .rx_done  (rx_done),
    .rx_count (rx_count)
);

// File: tb/tb_spis_cpha0_slave.sv
module tb_spis_cpha0_slave;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cpol = 1'b0;
    logic       lsb_first = 1'b0;
    logic       sclk = 1'b0;
    logic       cs_n = 1'b1;
    logic       mosi = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       miso, miso_oe, rx_done;
    logic [7:0] rx_data, rx_count;

    int checks = 0;
    int fails  = 0;
    int done_seen = 0;

    always #4 clk = ~clk;

    spis_cpha0_slave dut (
        .clk(clk), .rst(rst), .cpol(cpol), .lsb_first(lsb_first),
        .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .tx_data(tx_data),
        .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data),
        .rx_done(rx_done), .rx_count(rx_count)
    );

    always @(posedge clk) if (!rst && rx_done) done_seen++;

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int pos(input int b, input logic lsb);
        return lsb ? b : 7 - b;
    endfunction

    task automatic select_on();
        sclk = cpol;
        hold(2);
        cs_n = 1'b0;
        hold(6);
    endtask

    task automatic select_off();
        hold(HALF);
        cs_n = 1'b1;
        hold(6);
    endtask

    // drive n_edges clock edges; master sends mo, captures slave bits into got
    task automatic run_edges(input logic [7:0] mo, input int n_edges, output logic [7:0] got);
        got = '0;
        for (int b = 0; b < 8; b++) begin
            if (2 * b + 1 > n_edges) break;
            mosi = mo[pos(b, lsb_first)];
            hold(HALF);
            got[pos(b, lsb_first)] = miso;
            sclk = ~cpol;
            hold(HALF);
            if (2 * b + 2 > n_edges) break;
            sclk = cpol;
        end
        hold(6);
    endtask

    task automatic full_frame(input logic [7:0] mo, input logic [7:0] sl, input string req);
        logic [7:0] got;
        int d0;
        int c0;
        d0 = done_seen;
        c0 = int'(rx_count);
        tx_data = sl;
        select_on();
        check(miso_oe == 1'b1, req, miso_oe, 1);
        run_edges(mo, 16, got);
        check(got == sl, req, got, sl);
        check(rx_data == mo, req, rx_data, mo);
        check(done_seen == d0 + 1, req, done_seen - d0, 1);
        check(int'(rx_count) == ((c0 + 1) % 256), req, rx_count, (c0 + 1) % 256);
        select_off();
    endtask

    task automatic t_reset();
        check(rx_count == 8'd0 && rx_done == 1'b0, "R9", {rx_count, 7'd0, rx_done}, 0);
        check(rx_data == 8'd0, "R9", rx_data, 0);
        check(miso_oe == 1'b0, "R9", miso_oe, 0);
    endtask

    task automatic t_first_bit();
        cpol = 0; lsb_first = 0; tx_data = 8'hA1;
        select_on();
        check(miso_oe == 1'b1, "R1", miso_oe, 1);
        check(miso == 1'b1, "R2", miso, 1);
        select_off();
        check(miso_oe == 1'b0, "R1", miso_oe, 0);
        lsb_first = 1; tx_data = 8'h7E;
        select_on();
        check(miso == 1'b0, "R2", miso, 0);
        select_off();
        lsb_first = 0;
    endtask

    task automatic t_edge16();
        logic [7:0] got;
        int d0;
        int c0;
        cpol = 0; lsb_first = 0; tx_data = 8'h3C;
        d0 = done_seen;
        c0 = int'(rx_count);
        select_on();
        run_edges(8'h96, 15, got);
        check(done_seen == d0, "R5", done_seen - d0, 0);
        check(int'(rx_count) == c0, "R5", rx_count, c0);
        sclk = cpol;
        hold(6);
        check(done_seen == d0 + 1, "R5", done_seen - d0, 1);
        check(rx_data == 8'h96, "R5", rx_data, 8'h96);
        select_off();
    endtask

    task automatic t_abort();
        logic [7:0] got;
        logic [7:0] old;
        int d0;
        int c0;
        cpol = 0; lsb_first = 0; tx_data = 8'h55;
        old = rx_data;
        d0 = done_seen;
        c0 = int'(rx_count);
        select_on();
        run_edges(8'hFF, 5, got);
        select_off();
        check(done_seen == d0, "R7", done_seen - d0, 0);
        check(int'(rx_count) == c0, "R7", rx_count, c0);
        check(rx_data == old, "R7", rx_data, old);
        full_frame(8'h0F, 8'hC3, "R7");
    endtask

    task automatic t_back_to_back();
        logic [7:0] got;
        cpol = 0; lsb_first = 0; tx_data = 8'h81;
        select_on();
        mosi = 1'b0;
        hold(HALF);
        got[7] = miso;
        sclk = ~cpol;
        hold(HALF);
        tx_data = 8'h5A;
        sclk = cpol;
        for (int b = 1; b < 8; b++) begin
            mosi = 1'b1;
            hold(HALF);
            got[7 - b] = miso;
            sclk = ~cpol;
            hold(HALF);
            sclk = cpol;
        end
        hold(6);
        check(got == 8'h81, "R8", got, 8'h81);
        check(rx_data == 8'h7F, "R8", rx_data, 8'h7F);
        run_edges(8'h24, 16, got);
        check(got == 8'h5A, "R8", got, 8'h5A);
        check(rx_data == 8'h24, "R8", rx_data, 8'h24);
        select_off();
    endtask

    initial begin
        fork
            begin
                hold(5);
                rst = 1'b0;
                hold(2);
                t_reset();
                t_first_bit();
                cpol = 0; lsb_first = 0;
                full_frame(8'hB4, 8'h2D, "R3");
                full_frame(8'h01, 8'hE7, "R3");
                cpol = 0; lsb_first = 1;
                full_frame(8'hB4, 8'h2D, "R4");
                cpol = 1; lsb_first = 0;
                hold(4);
                full_frame(8'h6C, 8'h93, "R6");
                cpol = 1; lsb_first = 1;
                full_frame(8'hF0, 8'h1E, "R6");
                cpol = 0;
                hold(4);
                t_edge16();
                t_abort();
                t_back_to_back();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule